// File: doc/BRIEF.md
# Slow-Domain Register Write Synchronizer

This block sits between a fast register bus and a bank of registers clocked by a slow, always-on clock. Each bus write is captured in a single-entry holding buffer. It is then handed to the slow domain through a toggle request and a toggle acknowledge, with a multi-flop synchronizer in each direction. The bus side sees the progress of the write through four status flags: busy, ready-for-next, complete and error. Software polls these flags or takes an interrupt on them.

The interrupt-enable register is the only exception. A write to it is applied on the bus clock at once. It never occupies the synchronizer and never sets the completion flag. A write to the status register is itself a synchronized write: setting its error bit clears the error flag, but only when that write completes. The slow-domain registers are a plain register file, shown on an output port. The bus read path returns only the status and interrupt-enable words.

Reading the status register is the only way software sees completion. Any read that has side effects clears the completion flag. `busRdData` follows `busAddr` combinationally, so a read without `busRdEn` has no side effects.

Top module: `slow_reg_wsync`

## Requirements
- R1: After reset the status word is 0x200 (ready-for-next only), the interrupt-enable word is 0, `irq` is 0 and every slow register is 0.
- R2: A write to any address other than the interrupt-enable address (7), made while not busy, is accepted. From the next bus cycle the status shows busy (bit 10) set and ready-for-next (bit 9) clear. A write to slow register k (addresses 0 to 3) leaves the written data in slot k of `lpRegFile`, and the other slots are unchanged.
- R3: Busy clears and write-complete (bit 8) sets on the same bus cycle. This happens no later than three slow-clock periods plus four bus cycles after the accepting edge.
- R4: A read of the status register (address 6) with `busRdEn` high clears write-complete at the next edge. If completion arrives on that same edge, write-complete stays set.
- R5: A non-interrupt-enable write made while busy is dropped and sets write-error (bit 7). The write already in flight completes unchanged.
- R6: A status write with data bit 7 set goes through the synchronizer. Write-error stays set while that write is busy and clears when it completes. A status write with bit 7 clear leaves write-error set.
- R7: A write to the interrupt-enable address stores data bits 9:7, readable in the same bit positions on the next cycle. It sets neither busy nor write-complete, and is never dropped, even while busy.
- R8: `irq` is high exactly when enable bit 9 is set with ready-for-next, enable bit 8 with write-complete, or enable bit 7 with write-error.
- R9: Status bits other than 10:7 read 0, and reads of any address other than 6 and 7 return 0.
- R10: A write to an unmapped address (4 or 5) completes like any synchronized write and changes no slow register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Fast bus clock |
| busRstN | input | 1 | Bus-domain asynchronous reset, active low |
| lpClk | input | 1 | Slow low-power clock |
| lpRstN | input | 1 | Slow-domain asynchronous reset, active low |
| busWrEn | input | 1 | Write strobe, one bus cycle per write |
| busRdEn | input | 1 | Marks a read with side effects |
| busAddr | input | ADDR_W (3) | Register word address |
| busWrData | input | DATA_W (32) | Write data |
| busRdData | output | DATA_W (32) | Read data for `busAddr`, combinational |
| irq | output | 1 | Level interrupt |
| lpRegFile | output | NUM_LP_REGS*DATA_W (128) | Slow register contents, slot k at bits k*DATA_W upward |

## Verification
A busy flag stuck high stops every later write: each one is dropped and raises write-error on the next bus cycle. A lost toggle shows up as a write that never completes within its latency bound. If the error clear acts on acceptance rather than on completion, write-error reads low one cycle after a clearing write is accepted, while busy is still high. A wrong priority between a status read and completion makes one complete flag disappear in the very cycle that busy falls. The bench catches that by polling with side-effecting reads every cycle.

// File: rtl/wsync_pkg.sv
package wsync_pkg;
  // Status and interrupt-enable bit positions that software decodes
  localparam int BUSY_BIT = 10;
  localparam int NEXT_BIT = 9;
  localparam int DONE_BIT = 8;
  localparam int ERR_BIT  = 7;

  // Strobes from the bus-side control to the datapath
  typedef struct packed {
    logic accept;    // write captured into the holding buffer
    logic drop;      // write refused because busy
    logic done;      // acknowledge returned from the slow domain
    logic statRead;  // side-effecting read of the status word
    logic ienWrite;  // immediate interrupt-enable update
  } wsyncStrb_t;
endpackage

// File: rtl/wsync_bit.sv
module wsync_bit #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stageQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageQ <= '0;
    else       stageQ <= {stageQ[STAGES-2:0], d};
  end

  assign q = stageQ[STAGES-1];
endmodule

// File: rtl/wsync_ctrl.sv
module wsync_ctrl
  import wsync_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int STAT_ADDR   = 6,
  parameter int IEN_ADDR    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              busClk,
  input  logic              busRstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              ackTog,
  input  logic              errClrPending,
  output wsyncStrb_t        strb,
  output logic              reqTog,
  output logic              busy,
  output logic              wcf,
  output logic              wef
);
  localparam logic [ADDR_W-1:0] STAT_SEL = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] IEN_SEL  = ADDR_W'(IEN_ADDR);

  logic ackQ, ackSeenQ, reqTogQ, busyQ, wcfQ, wefQ;
  logic isIen;

  wsync_bit #(.STAGES(SYNC_STAGES)) ackSyncI (
    .clk(busClk), .rstN(busRstN), .d(ackTog), .q(ackQ)
  );

  always_comb begin
    isIen         = (busAddr == IEN_SEL);
    strb.ienWrite = busWrEn && isIen;
    strb.accept   = busWrEn && !isIen && !busyQ;
    strb.drop     = busWrEn && !isIen && busyQ;
    strb.statRead = busRdEn && (busAddr == STAT_SEL);
    strb.done     = ackQ ^ ackSeenQ;
  end

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      reqTogQ  <= 1'b0;
      ackSeenQ <= 1'b0;
      busyQ    <= 1'b0;
      wcfQ     <= 1'b0;
      wefQ     <= 1'b0;
    end else begin
      ackSeenQ <= ackQ;
      if (strb.accept) begin
        reqTogQ <= ~reqTogQ;
        busyQ   <= 1'b1;
      end else if (strb.done) begin
        busyQ   <= 1'b0;
      end
      // completion wins over a same-cycle status read
      if (strb.done)          wcfQ <= 1'b1;
      else if (strb.statRead) wcfQ <= 1'b0;
      // a new error wins over a clear arriving at completion
      if (strb.drop)                         wefQ <= 1'b1;
      else if (strb.done && errClrPending)   wefQ <= 1'b0;
    end
  end

  assign reqTog = reqTogQ;
  assign busy   = busyQ;
  assign wcf    = wcfQ;
  assign wef    = wefQ;
endmodule

// File: rtl/wsync_datapath.sv
module wsync_datapath
  import wsync_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 3,
  parameter int STAT_ADDR = 6,
  parameter int IEN_ADDR  = 7
) (
  input  logic              busClk,
  input  logic              busRstN,
  input  wsyncStrb_t        strb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busy,
  input  logic              wcf,
  input  logic              wef,
  output logic [ADDR_W-1:0] bufAddr,
  output logic [DATA_W-1:0] bufData,
  output logic              errClrPending,
  output logic [DATA_W-1:0] busRdData,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] STAT_SEL = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] IEN_SEL  = ADDR_W'(IEN_ADDR);
  localparam int IEN_W = NEXT_BIT - ERR_BIT + 1;

  logic [ADDR_W-1:0] bufAddrQ;
  logic [DATA_W-1:0] bufDataQ;
  logic [IEN_W-1:0]  ienQ;  // [2] next, [1] complete, [0] error

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      bufAddrQ <= '0;
      bufDataQ <= '0;
      ienQ     <= '0;
    end else begin
      if (strb.accept) begin
        bufAddrQ <= busAddr;
        bufDataQ <= busWrData;
      end
      if (strb.ienWrite) ienQ <= busWrData[NEXT_BIT:ERR_BIT];
    end
  end

  always_comb begin
    busRdData = '0;
    if (busAddr == STAT_SEL) begin
      busRdData[BUSY_BIT] = busy;
      busRdData[NEXT_BIT] = !busy;
      busRdData[DONE_BIT] = wcf;
      busRdData[ERR_BIT]  = wef;
    end else if (busAddr == IEN_SEL) begin
      busRdData[NEXT_BIT:ERR_BIT] = ienQ;
    end
  end

  assign irq           = (ienQ[2] && !busy) || (ienQ[1] && wcf) || (ienQ[0] && wef);
  assign errClrPending = (bufAddrQ == STAT_SEL) && bufDataQ[ERR_BIT];
  assign bufAddr       = bufAddrQ;
  assign bufData       = bufDataQ;
endmodule

// File: rtl/wsync_lp.sv
module wsync_lp #(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 3,
  parameter int NUM_LP_REGS = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          lpClk,
  input  logic                          lpRstN,
  input  logic                          reqTog,
  input  logic [ADDR_W-1:0]             bufAddr,
  input  logic [DATA_W-1:0]             bufData,
  output logic                          ackTog,
  output logic [NUM_LP_REGS*DATA_W-1:0] lpRegFile
);
  logic reqQ, seenQ, newReq;

  wsync_bit #(.STAGES(SYNC_STAGES)) reqSyncI (
    .clk(lpClk), .rstN(lpRstN), .d(reqTog), .q(reqQ)
  );

  assign newReq = reqQ ^ seenQ;

  always_ff @(posedge lpClk or negedge lpRstN) begin
    if (!lpRstN) seenQ <= 1'b0;
    else         seenQ <= reqQ;
  end

  // buffer is held stable by busy on the bus side until the ack returns
  for (genvar i = 0; i < NUM_LP_REGS; i++) begin : gSlot
    localparam logic [ADDR_W-1:0] SLOT_SEL = ADDR_W'(i);
    logic [DATA_W-1:0] regQ;
    always_ff @(posedge lpClk or negedge lpRstN) begin
      if (!lpRstN)                           regQ <= '0;
      else if (newReq && bufAddr == SLOT_SEL) regQ <= bufData;
    end
    assign lpRegFile[i*DATA_W +: DATA_W] = regQ;
  end

  assign ackTog = seenQ;
endmodule

// File: rtl/slow_reg_wsync.sv
module slow_reg_wsync
  import wsync_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 3,
  parameter int NUM_LP_REGS = 4,
  parameter int STAT_ADDR   = 6,
  parameter int IEN_ADDR    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          busClk,
  input  logic                          busRstN,
  input  logic                          lpClk,
  input  logic                          lpRstN,
  input  logic                          busWrEn,
  input  logic                          busRdEn,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [DATA_W-1:0]             busWrData,
  output logic [DATA_W-1:0]             busRdData,
  output logic                          irq,
  output logic [NUM_LP_REGS*DATA_W-1:0] lpRegFile
);
  wsyncStrb_t        strb;
  logic              reqTog, ackTog, busy, wcf, wef, errClrPending;
  logic [ADDR_W-1:0] bufAddr;
  logic [DATA_W-1:0] bufData;

  wsync_ctrl #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .IEN_ADDR(IEN_ADDR), .SYNC_STAGES(SYNC_STAGES)
  ) ctrlI (
    .busClk(busClk), .busRstN(busRstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .ackTog(ackTog), .errClrPending(errClrPending),
    .strb(strb), .reqTog(reqTog), .busy(busy), .wcf(wcf), .wef(wef)
  );

  wsync_datapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .IEN_ADDR(IEN_ADDR)
  ) dpI (
    .busClk(busClk), .busRstN(busRstN), .strb(strb), .busAddr(busAddr),
    .busWrData(busWrData), .busy(busy), .wcf(wcf), .wef(wef),
    .bufAddr(bufAddr), .bufData(bufData), .errClrPending(errClrPending),
    .busRdData(busRdData), .irq(irq)
  );

  wsync_lp #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_LP_REGS(NUM_LP_REGS), .SYNC_STAGES(SYNC_STAGES)
  ) lpI (
    .lpClk(lpClk), .lpRstN(lpRstN), .reqTog(reqTog), .bufAddr(bufAddr),
    .bufData(bufData), .ackTog(ackTog), .lpRegFile(lpRegFile)
  );
endmodule

// File: rtl/wsync_chk.sv
module wsync_chk #(
  parameter int ADDR_W    = 3,
  parameter int STAT_ADDR = 6,
  parameter int IEN_ADDR  = 7
) (
  input logic              busClk,
  input logic              busRstN,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busy,
  input logic              wcf,
  input logic              wef
);
  localparam logic [ADDR_W-1:0] STAT_SEL = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] IEN_SEL  = ADDR_W'(IEN_ADDR);

  // R2
  accept_sets_busy_chk: assert property (@(posedge busClk) disable iff (!busRstN)
    (busWrEn && busAddr != IEN_SEL && !busy) |=> busy);

  // R3
  done_with_fall_chk: assert property (@(posedge busClk) disable iff (!busRstN)
    $fell(busy) |-> wcf);

  // R4
  read_clears_done_chk: assert property (@(posedge busClk) disable iff (!busRstN)
    (busRdEn && busAddr == STAT_SEL && !busy) |=> !wcf);

  // R5
  drop_sets_error_chk: assert property (@(posedge busClk) disable iff (!busRstN)
    (busWrEn && busAddr != IEN_SEL && busy) |=> wef);

  // R6
  error_held_in_flight_chk: assert property (@(posedge busClk) disable iff (!busRstN)
    (wef && busy) |=> (wef || !busy));

  // R7
  ien_bypass_chk: assert property (@(posedge busClk) disable iff (!busRstN)
    (busWrEn && busAddr == IEN_SEL && !busy) |=> (!busy && $stable(wcf)));
endmodule

bind slow_reg_wsync wsync_chk #(
  .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .IEN_ADDR(IEN_ADDR)
) chkI (
  .busClk(busClk), .busRstN(busRstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
  .busAddr(busAddr), .busy(busy), .wcf(wcf), .wef(wef)
);

// File: tb/slow_reg_wsync_test.sv
module slow_reg_wsync_test;
  localparam int BUS_PERIOD = 20;
  localparam int LP_PERIOD  = 110;
  localparam int NREG       = 4;
  localparam logic [2:0] STAT = 3'd6;
  localparam logic [2:0] IEN  = 3'd7;
  localparam int LAT_BOUND  = (3*LP_PERIOD + BUS_PERIOD - 1) / BUS_PERIOD + 4;

  logic busClk = 0, lpClk = 0, busRstN = 0, lpRstN = 0;
  logic busWrEn = 0, busRdEn = 0;
  logic [2:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic irq;
  logic [NREG*32-1:0] lpRegFile;
  logic [31:0] model [NREG];
  int checks = 0, errors = 0;

  always #(BUS_PERIOD/2) busClk = ~busClk;
  always #(LP_PERIOD/2)  lpClk  = ~lpClk;

  slow_reg_wsync uut (
    .busClk(busClk), .busRstN(busRstN), .lpClk(lpClk), .lpRstN(lpRstN),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .irq(irq), .lpRegFile(lpRegFile)
  );

  function automatic logic [31:0] expStatus(input logic b, input logic c, input logic e);
    return (32'(b) << 10) | (32'(!b) << 9) | (32'(c) << 8) | (32'(e) << 7);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    busAddr = a; #1; d = busRdData;
  endtask

  task automatic doWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge busClk); busAddr = a; busWrData = d; busWrEn = 1;
    @(negedge busClk); busWrEn = 0;
  endtask

  task automatic doRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge busClk); busAddr = a; busRdEn = 1; #1; d = busRdData;
    @(negedge busClk); busRdEn = 0;
  endtask

  task automatic waitDone(output int cyc);
    cyc = 0; busAddr = STAT; #1;
    while (busRdData[10] && cyc < 200) begin
      @(negedge busClk); #1; cyc++;
    end
  endtask

  task automatic chkSlots(input string tag);
    for (int k = 0; k < NREG; k++) chk(tag, lpRegFile[k*32 +: 32], model[k]);
  endtask

  initial begin
    repeat (100000) @(posedge busClk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int cyc;
    for (int k = 0; k < NREG; k++) model[k] = '0;
    repeat (5) @(negedge busClk);
    busRstN = 1; lpRstN = 1;
    @(negedge busClk);

    // R1 / R9 reset state
    peek(STAT, d); chk("R1 status", d, expStatus(0, 0, 0));
    peek(IEN, d);  chk("R1 ien", d, 0);
    chk("R1 irq", 32'(irq), 0);
    chkSlots("R1 slots");
    for (int a = 0; a < 6; a++) begin
      peek(3'(a), d); chk("R9 other reads zero", d, 0);
    end

    // R2 / R3 sweep over slots and patterns
    for (int s = 0; s < NREG; s++) begin
      for (int p = 0; p < 3; p++) begin
        logic [31:0] v;
        v = (32'(s + 1) * 32'h01010101) ^ (32'(p) * 32'h9E3779B9);
        doWrite(3'(s), v);
        peek(STAT, d); chk("R2 busy after accept", d, expStatus(1, 0, 0));
        waitDone(cyc);
        chk("R3 latency bound", 32'(cyc <= LAT_BOUND), 1);
        chk("R3 done with busy fall", busRdData, expStatus(0, 1, 0));
        model[s] = v;
        chkSlots("R2 slot contents");
        doRead(STAT, d); chk("R4 read value", d, expStatus(0, 1, 0));
        peek(STAT, d);   chk("R4 cleared by read", d, expStatus(0, 0, 0));
      end
    end

    // R10 unmapped addresses
    for (int a = 4; a < 6; a++) begin
      doWrite(3'(a), 32'hDEAD0000 + 32'(a));
      waitDone(cyc);
      chk("R10 completes", busRdData, expStatus(0, 1, 0));
      chkSlots("R10 no slot change");
      doRead(STAT, d);
    end

    // R4 completion colliding with a side-effecting read
    doWrite(3'd0, 32'h0BADF00D); model[0] = 32'h0BADF00D;
    @(negedge busClk); busAddr = STAT; busRdEn = 1; #1; cyc = 0;
    while (busRdData[10] && cyc < 200) begin @(negedge busClk); #1; cyc++; end
    chk("R4 set wins over read", busRdData, expStatus(0, 1, 0));
    @(negedge busClk); #1;
    chk("R4 cleared next", busRdData, expStatus(0, 0, 0));
    busRdEn = 0;

    // R5 drop while busy
    doWrite(3'd1, 32'h11112222); model[1] = 32'h11112222;
    doWrite(3'd2, 32'h33334444);
    peek(STAT, d); chk("R5 error on drop", d, expStatus(1, 0, 1));
    waitDone(cyc);
    chk("R5 first completes", busRdData, expStatus(0, 1, 1));
    chkSlots("R5 dropped write absent");
    doRead(STAT, d);

    // R6 status write without bit 7 keeps the error
    doWrite(STAT, 32'h00000100);
    waitDone(cyc);
    chk("R6 no clear without bit7", busRdData, expStatus(0, 1, 1));
    doRead(STAT, d);
    // R6 clearing write acts on completion
    doWrite(STAT, 32'h00000080);
    peek(STAT, d); chk("R6 error held while busy", d, expStatus(1, 0, 1));
    waitDone(cyc);
    chk("R6 error cleared at done", busRdData, expStatus(0, 1, 0));
    doRead(STAT, d);
    chkSlots("R6 slots untouched");

    // R7 interrupt-enable bypass
    doWrite(IEN, 32'hFFFFFFFF);
    peek(IEN, d);  chk("R7 ien readback", d, 32'h380);
    peek(STAT, d); chk("R7 no busy no done", d, expStatus(0, 0, 0));
    doWrite(3'd3, 32'h55AA55AA); model[3] = 32'h55AA55AA;
    doWrite(IEN, 32'h00000000);
    peek(STAT, d); chk("R7 not dropped while busy", d, expStatus(1, 0, 0));
    peek(IEN, d);  chk("R7 ien updated while busy", d, 0);
    waitDone(cyc);
    doRead(STAT, d);

    // R8 irq sweep in several flag states
    for (int st = 0; st < 3; st++) begin
      logic c, e;
      c = (st == 1); e = (st == 2);
      if (st == 1) begin
        doWrite(3'd2, 32'h77778888); model[2] = 32'h77778888; waitDone(cyc);
      end
      if (st == 2) begin
        doRead(STAT, d);
        doWrite(3'd0, 32'h99990000); model[0] = 32'h99990000;
        doWrite(3'd1, 32'h12345678);
        waitDone(cyc); doRead(STAT, d);
      end
      for (int en = 0; en < 8; en++) begin
        doWrite(IEN, 32'(en) << 7);
        #1;
        chk("R8 irq", 32'(irq), 32'((en[2] && 1'b1) || (en[1] && c) || (en[0] && e)));
      end
    end
    doWrite(IEN, 32'h200);
    doWrite(3'd1, 32'h0);
    #1; chk("R8 next gated by busy", 32'(irq), 0);
    model[1] = 32'h0;
    waitDone(cyc);
    #1; chk("R8 next after done", 32'(irq), 1);
    chkSlots("R2 final slots");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule